// File: doc/BRIEF.md
# FSK Proximity ID Demodulator

This block turns a stream of 8-bit envelope amplitudes from a low-frequency proximity reader into 44-bit card identifiers. Each sample is sliced against a fixed threshold. The block counts the samples between rising edges of the sliced signal and sorts each spacing into a short carrier cycle (divide-by-8) or a long one (divide-by-10). Runs of equal cycle classes are then scaled to half-bit symbols. A start-of-frame marker is located in the symbol stream, and the Manchester pairs that follow are shifted into an identifier register.

The decoder is a small state machine with three states. HUNT slides over the symbol stream one symbol at a time and looks for the marker. COLLECT decodes one symbol pair per step. HALT is entered in find-one mode once the first identifier has been reported. The transitions are:
- HUNT to COLLECT when the marker is found.
- COLLECT to HUNT on a pair that is not a valid Manchester pair.
- COLLECT to COLLECT on a new marker. This reports a nonzero identifier and restarts collection.
- COLLECT to HALT when an identifier is reported while `find_one` is high.

An identifier is only reported when the marker of the following frame arrives. A reader that sends its frame repeatedly therefore yields one report per frame.

Top module: `fsk_id_demod`

## Requirements
- R1: A sample with value below 127 is taken as low, and 127 or above as high. Only cycles with `smp_valid` high advance the sample stream.
- R2: The spacing is the number of valid samples from one rising edge (low to high) to the next. The first rising edge after reset only starts the measurement. A spacing of 8 or less is class 1; a larger spacing is class 0. The spacing counter saturates at 255, and a saturated spacing is class 0.
- R3: When the class changes, the run that just ended is scaled to a count. Here n is the number of spacings in the run, not counting the spacing that began it. The count is (n+1)/6 for class 1 and (n+1)/5 for class 0, using integer division.
- R4: A count of 0 or 1 produces one half-bit symbol of the run's class. A count of 2, 3 or 4 produces that many symbols. A larger count produces none. No symbol is lost while the decoder is not halted.
- R5: In HUNT, the six consecutive symbols 1,1,1,0,0,0 (in arrival order) start collection.
- R6: In COLLECT, the pair 1,0 shifts a 0 into the identifier and the pair 0,1 shifts a 1. Bits enter at the LSB, and older bits leave through bit 43, so the first-sent bit ends up as the MSB.
- R7: In COLLECT, any other pair clears the identifier and returns the decoder to HUNT.
- R8: In COLLECT, the marker at a pair boundary reports a nonzero identifier. The report is a single-cycle `id_valid` pulse with `id_data`. The identifier is then cleared and collection restarts. A zero identifier is never reported.
- R9: If `find_one` is high when an identifier is reported, the decoder halts. It makes no further reports until reset.
- R10: Reset clears `id_valid` and `id_data` and puts the decoder in HUNT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| find_one | input | 1 | Halt after the first reported identifier |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 8 | Envelope amplitude sample |
| id_valid | output | 1 | One-cycle pulse marking a reported identifier |
| id_data | output | 44 | Last reported identifier |

## Verification
Reporting an identifier and starting the next frame happen in the same decoder step. The marker that closes one frame is also the marker that opens the next. The bench sends frames back to back with only one marker between them and checks that both identifiers come out, in order, with nothing extra. In find-one mode, the same coinciding step must instead report the first identifier and halt. The bench confirms this by sending a second frame afterwards and expecting no further report.

// File: rtl/fskd_pkg.sv
package fskd_pkg;
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_HALT    = 2'd2
    } dec_state_t;

    localparam int SYM_CNT_W = 3;
    localparam int MAX_SYMS  = 4;
    localparam int SOF_LEN   = 6;
    // arrival order 1,1,1,0,0,0 with bit 0 the oldest symbol
    localparam logic [SOF_LEN-1:0] SOF_PATTERN = 6'b000111;
endpackage

// File: rtl/fskd_edge_cls.sv
module fskd_edge_cls #(
    parameter int SMP_W   = 8,
    parameter int THRESH  = 127,
    parameter int CNT_W   = 8,
    parameter int FC8_MAX = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    output logic             cls_vld,
    output logic             cls
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(FC8_MAX);

    logic             prev_bit;
    logic             have_edge;
    logic [CNT_W-1:0] spacing;
    logic             bit_now;
    logic             rise;

    assign bit_now = (smp_data >= SMP_W'(THRESH));
    assign rise    = bit_now && !prev_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_bit  <= 1'b0;
            have_edge <= 1'b0;
            spacing   <= '0;
            cls_vld   <= 1'b0;
            cls       <= 1'b0;
        end else begin
            cls_vld <= 1'b0;
            if (smp_valid) begin
                prev_bit <= bit_now;
                if (rise) begin
                    have_edge <= 1'b1;
                    spacing   <= CNT_W'(1);
                    cls_vld   <= have_edge;
                    cls       <= (spacing != CNT_MAX) && (spacing <= SHORT_LIM);
                end else if (spacing != CNT_MAX) begin
                    spacing <= spacing + CNT_W'(1);
                end
            end
        end
    end

    assert_cls_from_sample_R2: assert property (@(posedge clk) disable iff (rst)
        cls_vld |-> $past(smp_valid));
endmodule

// File: rtl/fskd_run_sym.sv
module fskd_run_sym
    import fskd_pkg::*;
#(
    parameter int RUN_W  = 8,
    parameter int DIV_S  = 6,
    parameter int DIV_L  = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cls_vld,
    input  logic                 cls,
    output logic                 sym_vld,
    output logic                 sym_cls,
    output logic [SYM_CNT_W-1:0] sym_cnt
);
    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

    logic             have_run;
    logic             cur_cls;
    logic [RUN_W-1:0] run_n;
    logic [RUN_W:0]   scaled;
    logic [SYM_CNT_W-1:0] emit_k;

    always_comb begin
        if (cur_cls)
            scaled = ({1'b0, run_n} + (RUN_W+1)'(1)) / (RUN_W+1)'(DIV_S);
        else
            scaled = ({1'b0, run_n} + (RUN_W+1)'(1)) / (RUN_W+1)'(DIV_L);
        if (scaled <= (RUN_W+1)'(1))
            emit_k = SYM_CNT_W'(1);
        else if (scaled <= (RUN_W+1)'(MAX_SYMS))
            emit_k = scaled[SYM_CNT_W-1:0];
        else
            emit_k = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_run <= 1'b0;
            cur_cls  <= 1'b0;
            run_n    <= '0;
            sym_vld  <= 1'b0;
            sym_cls  <= 1'b0;
            sym_cnt  <= '0;
        end else begin
            sym_vld <= 1'b0;
            if (cls_vld) begin
                if (!have_run) begin
                    have_run <= 1'b1;
                    cur_cls  <= cls;
                    run_n    <= '0;
                end else if (cls == cur_cls) begin
                    if (run_n != RUN_MAX)
                        run_n <= run_n + RUN_W'(1);
                end else begin
                    sym_vld  <= (emit_k != '0);
                    sym_cls  <= cur_cls;
                    sym_cnt  <= emit_k;
                    cur_cls  <= cls;
                    run_n    <= '0;
                end
            end
        end
    end

    assert_sym_after_class_R3: assert property (@(posedge clk) disable iff (rst)
        sym_vld |-> $past(cls_vld));
    assert_sym_count_range_R4: assert property (@(posedge clk) disable iff (rst)
        sym_vld |-> (sym_cnt != '0) && (sym_cnt <= SYM_CNT_W'(MAX_SYMS)));
endmodule

// File: rtl/fskd_frame_dec.sv
module fskd_frame_dec
    import fskd_pkg::*;
#(
    parameter int ID_W = 44,
    parameter int BUF  = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 find_one,
    input  logic                 sym_vld,
    input  logic                 sym_cls,
    input  logic [SYM_CNT_W-1:0] sym_cnt,
    output logic                 id_valid,
    output logic [ID_W-1:0]      id_data
);
    localparam int FILL_W = $clog2(BUF + 1);

    dec_state_t state_q, state_d;

    logic [BUF-1:0]    win_q, win_d;
    logic [FILL_W-1:0] fill_q, fill_d;
    logic [FILL_W-1:0] used, kept;
    logic [FILL_W:0]   fill_sum;
    logic [BUF-1:0]    ones;
    logic [ID_W-1:0]   id_q;
    logic              can_step, is_sof, pair_zero, pair_one, app;
    logic              report, clr, shift_en;

    assign can_step  = (fill_q >= FILL_W'(SOF_LEN)) && (state_q != ST_HALT);
    assign is_sof    = (win_q[SOF_LEN-1:0] == SOF_PATTERN);
    assign pair_zero = (win_q[1:0] == 2'b01);
    assign pair_one  = (win_q[1:0] == 2'b10);
    assign app       = sym_vld && (state_q != ST_HALT);

    always_comb begin
        state_d  = state_q;
        used     = '0;
        report   = 1'b0;
        clr      = 1'b0;
        shift_en = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (can_step) begin
                    if (is_sof) begin
                        used    = FILL_W'(SOF_LEN);
                        state_d = ST_COLLECT;
                    end else begin
                        used = FILL_W'(1);
                    end
                end
            end
            ST_COLLECT: begin
                if (can_step) begin
                    if (is_sof) begin
                        used   = FILL_W'(SOF_LEN);
                        clr    = 1'b1;
                        report = (id_q != '0);
                        if (report && find_one)
                            state_d = ST_HALT;
                    end else begin
                        used = FILL_W'(2);
                        if (pair_zero || pair_one) begin
                            shift_en = 1'b1;
                        end else begin
                            clr     = 1'b1;
                            state_d = ST_HUNT;
                        end
                    end
                end
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    always_comb begin
        kept     = fill_q - used;
        fill_sum = {1'b0, kept} + (app ? (FILL_W+1)'(sym_cnt) : '0);
        fill_d   = fill_sum[FILL_W-1:0];
        ones     = ~({BUF{1'b1}} << sym_cnt);
        win_d    = (win_q >> used) | ((app && sym_cls) ? (ones << kept) : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HUNT;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q    <= '0;
            fill_q   <= '0;
            id_q     <= '0;
            id_valid <= 1'b0;
            id_data  <= '0;
        end else begin
            win_q    <= win_d;
            fill_q   <= fill_d;
            id_valid <= report;
            if (report)
                id_data <= id_q;
            if (clr)
                id_q <= '0;
            else if (shift_en)
                id_q <= {id_q[ID_W-2:0], pair_one};
        end
    end

    assert_buf_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        fill_sum <= (FILL_W+1)'(BUF));
    assert_bad_pair_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COLLECT && state_d == ST_HUNT) |=> (id_q == '0));
    assert_report_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
        id_valid |-> (id_data != '0) && ($past(state_q) == ST_COLLECT));
    assert_halt_silent_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT) |=> (state_q == ST_HALT) && !id_valid);
endmodule

// File: rtl/fsk_id_demod.sv
module fsk_id_demod #(
    parameter int SMP_W   = 8,
    parameter int THRESH  = 127,
    parameter int CNT_W   = 8,
    parameter int FC8_MAX = 8,
    parameter int ID_W    = 44,
    parameter int SYM_BUF = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             find_one,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    output logic             id_valid,
    output logic [ID_W-1:0]  id_data
);
    logic       cls_vld, cls;
    logic       sym_vld, sym_cls;
    logic [fskd_pkg::SYM_CNT_W-1:0] sym_cnt;

    fskd_edge_cls #(
        .SMP_W(SMP_W), .THRESH(THRESH), .CNT_W(CNT_W), .FC8_MAX(FC8_MAX)
    ) u_edge (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .cls_vld(cls_vld), .cls(cls)
    );

    fskd_run_sym #(
        .RUN_W(8), .DIV_S(6), .DIV_L(5)
    ) u_run (
        .clk(clk), .rst(rst), .cls_vld(cls_vld), .cls(cls),
        .sym_vld(sym_vld), .sym_cls(sym_cls), .sym_cnt(sym_cnt)
    );

    fskd_frame_dec #(
        .ID_W(ID_W), .BUF(SYM_BUF)
    ) u_dec (
        .clk(clk), .rst(rst), .find_one(find_one),
        .sym_vld(sym_vld), .sym_cls(sym_cls), .sym_cnt(sym_cnt),
        .id_valid(id_valid), .id_data(id_data)
    );
endmodule

// File: tb/fsk_id_demod_test.sv
module fsk_id_demod_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        find_one = 1'b0;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_data = 8'd0;
    logic        id_valid;
    logic [43:0] id_data;

    always #4 clk = ~clk;

    fsk_id_demod uut (
        .clk(clk), .rst(rst), .find_one(find_one),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .id_valid(id_valid), .id_data(id_data)
    );

    int checks = 0;
    int failures = 0;
    logic [43:0] exp_q[$];
    string       tag_q[$];
    bit          sq[$];
    int g_p8 = 8, g_p10 = 10, g_gap = 0;
    logic [7:0] g_hi = 8'd200, g_lo = 8'd40;
    bit done = 0;

    task automatic fail_line(string req, string what, logic [63:0] act, logic [63:0] exp);
        failures++;
        $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    endtask

    always @(negedge clk) begin
        if (!rst && id_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fail_line("R8/R9", "unexpected report", 64'(id_data), 64'h0);
            end else begin
                automatic logic [43:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (id_data !== e) fail_line(t, "id mismatch", 64'(id_data), 64'(e));
            end
        end
    end

    task automatic expect_id(logic [43:0] v, string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic drive(logic [7:0] v);
        repeat (g_gap) begin
            @(negedge clk);
            smp_valid = 1'b0;
        end
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = v;
    endtask

    task automatic put_pattern(bit c);
        int p  = c ? g_p8 : g_p10;
        int nh = c ? 2 : 3;
        for (int s = 0; s < p; s++) drive(s < nh ? g_hi : g_lo);
    endtask

    task automatic push_sof();
        sq.push_back(1); sq.push_back(1); sq.push_back(1);
        sq.push_back(0); sq.push_back(0); sq.push_back(0);
    endtask

    task automatic push_bit(bit b);
        sq.push_back(!b);
        sq.push_back(b);
    endtask

    task automatic push_id(logic [43:0] v);
        push_sof();
        push_bit(1'b0);
        for (int i = 43; i >= 0; i--) push_bit(v[i]);
    endtask

    task automatic close_frame();
        push_sof();
        push_bit(1'b0);
        sq.push_back(0);
    endtask

    task automatic flush_syms();
        int i = 0;
        while (i < sq.size()) begin
            automatic bit c = sq[i];
            automatic int len = 0;
            while (i < sq.size() && sq[i] == c) begin
                len++;
                i++;
            end
            for (int k = 0; k < (c ? 6 * len : 5 * len); k++) put_pattern(c);
        end
        sq.delete();
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic check_drained(string t);
        checks++;
        if (exp_q.size() != 0)
            fail_line(t, "missing report(s)", 64'(exp_q.size()), 64'h0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        g_p8 = 8; g_p10 = 10; g_gap = 0; g_hi = 8'd200; g_lo = 8'd40;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        checks++;
        if (id_valid !== 1'b0) fail_line("R10", "id_valid at reset", 64'(id_valid), 64'h0);
        checks++;
        if (id_data !== 44'h0) fail_line("R10", "id_data at reset", 64'(id_data), 64'h0);
        do_reset();

        // R3 R5 R6: one frame, reported by the next marker
        sq.push_back(0);
        push_id(44'h9AB_CDEF_0123);
        close_frame();
        expect_id(44'h9AB_CDEF_0123, "R6");
        flush_syms();
        check_drained("R5");

        // R8: back-to-back frames, report and restart in one step
        do_reset();
        sq.push_back(0);
        push_id(44'h123_4567_89AB);
        push_id(44'hFED_CBA9_8765);
        close_frame();
        expect_id(44'h123_4567_89AB, "R8");
        expect_id(44'hFED_CBA9_8765, "R8");
        flush_syms();
        check_drained("R8");

        // R9: find-one halts after first report
        do_reset();
        find_one = 1'b1;
        sq.push_back(0);
        push_id(44'h0AA_5555_F00F);
        push_id(44'h123_4567_89AB);
        close_frame();
        expect_id(44'h0AA_5555_F00F, "R9");
        flush_syms();
        push_id(44'hFED_CBA9_8765);
        close_frame();
        flush_syms();
        check_drained("R9");
        find_one = 1'b0;

        // R1: samples of exactly 127 are high, 126 low
        do_reset();
        g_hi = 8'd127; g_lo = 8'd126;
        sq.push_back(0);
        push_id(44'h001_0000_0001);
        close_frame();
        expect_id(44'h001_0000_0001, "R1");
        flush_syms();
        check_drained("R1");

        // R2: spacing 8 is short, 9 is long (boundary), and 7 short
        do_reset();
        g_p8 = 7; g_p10 = 9;
        sq.push_back(0);
        push_id(44'h5A5_A5A5_A5A5);
        close_frame();
        expect_id(44'h5A5_A5A5_A5A5, "R2");
        flush_syms();
        check_drained("R2");

        // R7: bad pair aborts the frame; only the next good frame reports
        do_reset();
        sq.push_back(0);
        push_sof();
        push_bit(1'b0);
        sq.push_back(1); sq.push_back(1);
        for (int i = 0; i < 4; i++) push_bit(1'b1);
        push_id(44'h321_0FED_CBA9);
        close_frame();
        expect_id(44'h321_0FED_CBA9, "R7");
        flush_syms();
        check_drained("R7");

        // R4: a five-symbol run emits nothing, so its marker is lost
        do_reset();
        sq.push_back(0);
        for (int i = 0; i < 5; i++) sq.push_back(1);
        sq.push_back(0); sq.push_back(0); sq.push_back(0);
        for (int i = 0; i < 4; i++) push_bit(1'b1);
        push_id(44'h0F0_F0F0_F0F0);
        close_frame();
        expect_id(44'h0F0_F0F0_F0F0, "R4");
        flush_syms();
        check_drained("R4");

        // R1: idle cycles between valid samples are not counted
        do_reset();
        g_gap = 1;
        sq.push_back(0);
        push_id(44'h777_1234_4321);
        close_frame();
        expect_id(44'h777_1234_4321, "R1");
        flush_syms();
        check_drained("R1");

        // R2: saturated spacing after a long low gap counts as long class
        do_reset();
        for (int i = 0; i < 6; i++) put_pattern(1'b0);
        for (int i = 0; i < 300; i++) drive(8'd10);
        sq.push_back(0);
        push_id(44'hC3C_3C3C_3C3C);
        close_frame();
        expect_id(44'hC3C_3C3C_3C3C, "R2");
        flush_syms();
        check_drained("R2");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule